// File: doc/BRIEF.md
# Serial Pattern Channel Engine

This block drives one two-wire output channel: a divided clock line and a data line. Software-facing logic elsewhere supplies a pattern of up to 64 bits, a length, a repeat count, a clock pre-divider, an edge polarity and two idle levels. When the enable input rises, the block shifts the pattern out on the data line, least significant bit first, in step with the clock line it generates. It can repeat the pattern many times with no gap between repetitions. When the last bit of the last repetition is done, it returns both lines to their idle levels and pulses a completion flag.

The configuration pins are plain control inputs, and no data stream handshake applies. The block keeps its own copy of every configuration value. This copy tracks the pins on each clock edge while the enable input is low and stays frozen while the enable input is high. Both outputs come straight from flip-flops, so they never glitch.

A run starts at the first rising clock edge that samples the enable input high while the block is idle. That edge is called the start edge, and cycle k is the cycle after start edge + k.

Top module: `pattern_chan`

## Requirements
- R1: The length field `len_m1_i` holds the pattern length minus one. A value of 0 sends 1 bit, and a value of 63 sends all 64 bits.
- R2: The 10-bit repeat field `rep_m1_i` holds the number of repetitions minus one. A value of 0 sends the pattern once, and 10'h3ff sends it 1024 times. Bit 0 follows the last bit of a repetition directly, with no idle gap.
- R3: `pattern_i[i]` is the i-th bit sent. Bit 0 goes first, so bits 31:0 go out before bits 63:32.
- R4: The clock line keeps its idle level until cycle N+1, where N is the pre-divider value. From then on it inverts every N+1 cycles, which gives a period of 2*(N+1) system clocks. N=0 inverts it every cycle.
- R5: Bit 0 appears on `pda_o` in cycle 0. With `pol_i`=0, the data changes only when `pcl_o` falls; with `pol_i`=1, only when it rises. If the first inversion of the clock line is a change edge, the data does not advance there.
- R6: Whenever no run is in progress, `pcl_o` and `pda_o` equal the latched idle levels. This covers the time after completion while enable stays high. After reset, all outputs are 0.
- R7: Configuration pins are captured on every edge that samples enable low, so a value must be present for one such edge before a start. While enable is high, changing any configuration pin has no effect on the outputs.
- R8: At the change edge after the final bit of the final repetition, both lines go to their idle levels and `done_o` is high for exactly one cycle. A new run needs enable low for at least one edge first.
- R9: If enable is sampled low during a run, the next cycle shows the idle levels and `done_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Start (rising) and abort (low) control |
| pattern_i | input | 64 | Pattern bits, bit 0 sent first |
| len_m1_i | input | 6 | Pattern length minus one |
| rep_m1_i | input | 10 | Repetition count minus one |
| prediv_i | input | 32 | Clock pre-divider N |
| pol_i | input | 1 | 0: data changes on the falling clock; 1: on the rising clock |
| idle_clk_i | input | 1 | Clock line level while inactive |
| idle_dat_i | input | 1 | Data line level while inactive |
| pcl_o | output | 1 | Generated clock line |
| pda_o | output | 1 | Serial data line |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches several rules on every cycle:
- the clock line inverts only at a divider terminal count;
- the data line moves only together with a clock inversion onto the change level;
- the latched configuration stays still during a run;
- the completion pulse lasts one cycle and coincides with idle levels;
- an abort lands on the idle levels.

Only the bench's sweeps can show the full waveforms against arithmetic expectations:
- the exact bit order and length decoding;
- gapless repetition;
- the cycle of the first clock inversion;
- the completion cycle for each combination of divider, polarity and idle levels;
- that configuration changed mid-run is ignored.

// File: rtl/pattern_chan_pkg.sv
package pattern_chan_pkg;

  typedef enum logic [1:0] {
    PC_IDLE = 2'd0,
    PC_RUN  = 2'd1,
    PC_HOLD = 2'd2
  } pc_state_e;

  // A clock inversion is a change edge when the new clock level equals the polarity.
  function automatic logic pc_is_change(input logic new_clk, input logic pol);
    return new_clk == pol;
  endfunction

endpackage

// File: rtl/pattern_chan_cfg.sv
module pattern_chan_cfg #(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 6,
  parameter int REP_W  = 10,
  parameter int DIV_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic [DATA_W-1:0] pattern_i,
  input  logic [LEN_W-1:0]  len_m1_i,
  input  logic [REP_W-1:0]  rep_m1_i,
  input  logic [DIV_W-1:0]  prediv_i,
  input  logic              pol_i,
  input  logic              idle_clk_i,
  input  logic              idle_dat_i,
  output logic [DATA_W-1:0] pattern_q,
  output logic [LEN_W-1:0]  len_q,
  output logic [REP_W-1:0]  rep_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              pol_q,
  output logic              idle_clk_q,
  output logic              idle_dat_q
);

  // Shadow copy follows the pins while disabled and is frozen while enabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pattern_q  <= '0;
      len_q      <= '0;
      rep_q      <= '0;
      div_q      <= '0;
      pol_q      <= 1'b0;
      idle_clk_q <= 1'b0;
      idle_dat_q <= 1'b0;
    end else if (!enable_i) begin
      pattern_q  <= pattern_i;
      len_q      <= len_m1_i;
      rep_q      <= rep_m1_i;
      div_q      <= prediv_i;
      pol_q      <= pol_i;
      idle_clk_q <= idle_clk_i;
      idle_dat_q <= idle_dat_i;
    end
  end

endmodule

// File: rtl/pattern_chan_div.sv
module pattern_chan_div #(
  parameter int DIV_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic [DIV_W-1:0] cnt_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             at_term;

  assign at_term = (cnt_q == div_i);
  assign tick_o  = run_i && at_term;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i || at_term) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pattern_chan_seq.sv
module pattern_chan_seq #(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 6,
  parameter int REP_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              advance_i,
  input  logic [DATA_W-1:0] pattern_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [REP_W-1:0]  rep_i,
  output logic              first_bit_o,
  output logic              next_bit_o,
  output logic              last_o
);

  logic [LEN_W-1:0] idx_q;
  logic [REP_W-1:0] rep_q;
  logic             wrap;
  logic [LEN_W-1:0] idx_nxt;

  assign wrap        = (idx_q == len_i);
  assign idx_nxt     = wrap ? '0 : LEN_W'(idx_q + 1'b1);
  assign next_bit_o  = pattern_i[idx_nxt];
  assign first_bit_o = pattern_i[0];
  assign last_o      = wrap && (rep_q == rep_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      rep_q <= '0;
    end else if (load_i) begin
      idx_q <= '0;
      rep_q <= '0;
    end else if (advance_i) begin
      idx_q <= idx_nxt;
      if (wrap) begin
        rep_q <= REP_W'(rep_q + 1'b1);
      end
    end
  end

endmodule

// File: rtl/pattern_chan.sv
module pattern_chan
  import pattern_chan_pkg::*;
#(
  parameter int  DATA_W = 64,
  parameter int  REP_W  = 10,
  parameter int  DIV_W  = 32,
  localparam int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic [DATA_W-1:0] pattern_i,
  input  logic [LEN_W-1:0]  len_m1_i,
  input  logic [REP_W-1:0]  rep_m1_i,
  input  logic [DIV_W-1:0]  prediv_i,
  input  logic              pol_i,
  input  logic              idle_clk_i,
  input  logic              idle_dat_i,
  output logic              pcl_o,
  output logic              pda_o,
  output logic              done_o
);

  logic [DATA_W-1:0] cfg_pattern;
  logic [LEN_W-1:0]  cfg_len;
  logic [REP_W-1:0]  cfg_rep;
  logic [DIV_W-1:0]  cfg_div;
  logic              cfg_pol;
  logic              cfg_idle_clk;
  logic              cfg_idle_dat;

  pc_state_e         state_q;
  logic              pcl_q;
  logic              pda_q;
  logic              done_q;
  logic              sampled_q;

  logic              run_w;
  logic              tick;
  logic [DIV_W-1:0]  div_cnt;
  logic              change_edge;
  logic              load;
  logic              advance;
  logic              finish;
  logic              first_bit;
  logic              next_bit;
  logic              last_bit;

  pattern_chan_cfg #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .REP_W(REP_W), .DIV_W(DIV_W)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_i),
    .pattern_i  (pattern_i),
    .len_m1_i   (len_m1_i),
    .rep_m1_i   (rep_m1_i),
    .prediv_i   (prediv_i),
    .pol_i      (pol_i),
    .idle_clk_i (idle_clk_i),
    .idle_dat_i (idle_dat_i),
    .pattern_q  (cfg_pattern),
    .len_q      (cfg_len),
    .rep_q      (cfg_rep),
    .div_q      (cfg_div),
    .pol_q      (cfg_pol),
    .idle_clk_q (cfg_idle_clk),
    .idle_dat_q (cfg_idle_dat)
  );

  assign run_w = (state_q == PC_RUN);

  pattern_chan_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_w && enable_i),
    .div_i  (cfg_div),
    .tick_o (tick),
    .cnt_o  (div_cnt)
  );

  assign change_edge = pc_is_change(~pcl_q, cfg_pol);
  assign load        = (state_q == PC_IDLE) && enable_i;
  assign finish      = tick && change_edge && sampled_q && last_bit;
  assign advance     = tick && change_edge && sampled_q && !last_bit;

  pattern_chan_seq #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .REP_W(REP_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .advance_i   (advance),
    .pattern_i   (cfg_pattern),
    .len_i       (cfg_len),
    .rep_i       (cfg_rep),
    .first_bit_o (first_bit),
    .next_bit_o  (next_bit),
    .last_o      (last_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PC_IDLE;
      pcl_q     <= 1'b0;
      pda_q     <= 1'b0;
      done_q    <= 1'b0;
      sampled_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        PC_IDLE: begin
          pcl_q     <= cfg_idle_clk;
          pda_q     <= cfg_idle_dat;
          sampled_q <= 1'b0;
          if (enable_i) begin
            state_q <= PC_RUN;
            pda_q   <= first_bit;
          end
        end
        PC_RUN: begin
          if (!enable_i) begin
            state_q <= PC_IDLE;
            pcl_q   <= cfg_idle_clk;
            pda_q   <= cfg_idle_dat;
          end else if (finish) begin
            state_q <= PC_HOLD;
            pcl_q   <= cfg_idle_clk;
            pda_q   <= cfg_idle_dat;
            done_q  <= 1'b1;
          end else if (tick) begin
            pcl_q <= ~pcl_q;
            if (!change_edge) begin
              sampled_q <= 1'b1;
            end else if (sampled_q) begin
              pda_q     <= next_bit;
              sampled_q <= 1'b0;
            end
          end
        end
        PC_HOLD: begin
          pcl_q <= cfg_idle_clk;
          pda_q <= cfg_idle_dat;
          if (!enable_i) begin
            state_q <= PC_IDLE;
          end
        end
        default: begin
          state_q <= PC_IDLE;
        end
      endcase
    end
  end

  assign pcl_o  = pcl_q;
  assign pda_o  = pda_q;
  assign done_o = done_q;

endmodule

// File: rtl/pattern_chan_chk.sv
module pattern_chan_chk #(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 6,
  parameter int REP_W  = 10,
  parameter int DIV_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable_i,
  input logic              pcl_o,
  input logic              pda_o,
  input logic              done_o,
  input logic              run_w,
  input logic [DIV_W-1:0]  div_cnt,
  input logic [DATA_W-1:0] cfg_pattern,
  input logic [LEN_W-1:0]  cfg_len,
  input logic [REP_W-1:0]  cfg_rep,
  input logic [DIV_W-1:0]  cfg_div,
  input logic              cfg_pol,
  input logic              cfg_idle_clk,
  input logic              cfg_idle_dat
);

  AST_PCL_AT_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && $past(run_w) && (pcl_o != $past(pcl_o))) |-> ($past(div_cnt) == cfg_div)); // R4

  AST_PDA_ON_CHANGE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && $past(run_w) && (pda_o != $past(pda_o))) |-> ((pcl_o != $past(pcl_o)) && (pcl_o == cfg_pol))); // R5

  AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!run_w && (pcl_o == cfg_idle_clk) && (pda_o == cfg_idle_dat))); // R6

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && $past(run_w)) |-> ($stable(cfg_pattern) && $stable(cfg_len) && $stable(cfg_rep)
                                 && $stable(cfg_div) && $stable(cfg_pol)
                                 && $stable(cfg_idle_clk) && $stable(cfg_idle_dat))); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_w) && !$past(enable_i)) |-> (!run_w && !done_o && (pcl_o == $past(cfg_idle_clk))
                                             && (pda_o == $past(cfg_idle_dat)))); // R9

endmodule

bind pattern_chan pattern_chan_chk #(
  .DATA_W(DATA_W), .LEN_W(LEN_W), .REP_W(REP_W), .DIV_W(DIV_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable_i     (enable_i),
  .pcl_o        (pcl_o),
  .pda_o        (pda_o),
  .done_o       (done_o),
  .run_w        (run_w),
  .div_cnt      (div_cnt),
  .cfg_pattern  (cfg_pattern),
  .cfg_len      (cfg_len),
  .cfg_rep      (cfg_rep),
  .cfg_div      (cfg_div),
  .cfg_pol      (cfg_pol),
  .cfg_idle_clk (cfg_idle_clk),
  .cfg_idle_dat (cfg_idle_dat)
);

// File: tb/pattern_chan_tb_top.sv
module pattern_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [63:0] pat = '0;
  logic [5:0]  len = '0;
  logic [9:0]  rep = '0;
  logic [31:0] div = '0;
  logic        pol = 1'b0;
  logic        ic = 1'b0;
  logic        id = 1'b0;
  logic        pcl, pda, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pattern_chan dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (en),
    .pattern_i  (pat),
    .len_m1_i   (len),
    .rep_m1_i   (rep),
    .prediv_i   (div),
    .pol_i      (pol),
    .idle_clk_i (ic),
    .idle_dat_i (id),
    .pcl_o      (pcl),
    .pda_o      (pda),
    .done_o     (done)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual pcl/pda/done=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=190000 cycles", cycles);
      finish_run();
    end
  end

  // One run with expected outputs derived from the requirement arithmetic.
  task automatic run_case(input int n, input bit p, input bit lc, input bit ld,
                          input int l, input int r, input logic [63:0] d,
                          input int abort_at, input bit scramble);
    int          L, B, t_end, k_end, t, adv;
    bit          first_change;
    logic [2:0]  exp;
    @(negedge clk);
    en = 1'b0; div = 32'(n); pol = p; ic = lc; id = ld;
    len = 6'(l); rep = 10'(r); pat = d;
    @(negedge clk);
    @(negedge clk);
    check("R6 idle before start", {pcl, pda, done}, {lc, ld, 1'b0});
    en = 1'b1;
    L = l + 1;
    B = L * (r + 1);
    first_change = (lc != p);
    t_end = first_change ? 2 * B + 1 : 2 * B;
    k_end = t_end * (n + 1);
    for (int k = 0; k <= k_end + 3; k++) begin
      @(negedge clk);
      t = k / (n + 1);
      adv = first_change ? ((t > 0) ? (t - 1) / 2 : 0) : t / 2;
      if (k < k_end) begin
        exp = {lc ^ t[0], d[adv % L], 1'b0};
        check("R1 R2 R3 R4 R5 running", {pcl, pda, done}, exp);
      end else if (k == k_end) begin
        check("R8 completion", {pcl, pda, done}, {lc, ld, 1'b1});
      end else begin
        check("R6 held idle after done", {pcl, pda, done}, {lc, ld, 1'b0});
      end
      if (scramble && k == 1) begin
        // R7: configuration changes while enabled must be ignored.
        pat = ~d; len = 6'(l + 3); rep = 10'(r + 2); div = 32'(n + 5);
        pol = ~p; ic = ~lc; id = ~ld;
      end
      if (abort_at >= 0 && k == abort_at) begin
        en = 1'b0;
        @(negedge clk);
        check("R9 abort to idle", {pcl, pda, done}, {lc, ld, 1'b0});
        return;
      end
    end
    en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset state", {pcl, pda, done}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 idle after reset", {pcl, pda, done}, 3'b000);

    // Sweep over divider, polarity, idle levels, length and repeat count.
    for (int n = 0; n < 3; n++) begin
      for (int p = 0; p < 2; p++) begin
        for (int lc = 0; lc < 2; lc++) begin
          for (int ld = 0; ld < 2; ld++) begin
            for (int li = 0; li < 4; li++) begin
              for (int r = 0; r < 3; r++) begin
                int l;
                l = (li == 3) ? 5 : li;
                run_case(n, p[0], lc[0], ld[0], l, r,
                         64'h6B2D_9471_A5C3_0F1E ^ 64'(n * 977 + li * 31 + r),
                         -1, 1'b0);
              end
            end
          end
        end
      end
    end

    // R3 word order over the full 64-bit length (R1 upper bound).
    run_case(0, 1'b0, 1'b1, 1'b0, 63, 1, 64'hFFFF_FFFF_0000_0001, -1, 1'b0);
    run_case(1, 1'b1, 1'b0, 1'b1, 63, 0, 64'h8000_0000_7FFF_FFFE, -1, 1'b0);
    // R2 maximum repeat count.
    run_case(0, 1'b1, 1'b1, 1'b0, 0, 1023, 64'h1, -1, 1'b0);
    // R7 frozen configuration.
    run_case(1, 1'b0, 1'b0, 1'b1, 4, 2, 64'h0000_0000_0000_0013, -1, 1'b1);
    run_case(2, 1'b1, 1'b1, 1'b1, 7, 1, 64'h0000_0000_0000_00C5, -1, 1'b1);
    // R9 aborts at several points.
    run_case(1, 1'b0, 1'b1, 1'b0, 5, 2, 64'h2D, 0, 1'b0);
    run_case(1, 1'b0, 1'b1, 1'b0, 5, 2, 64'h2D, 7, 1'b0);
    run_case(0, 1'b1, 1'b0, 1'b1, 3, 1, 64'h9, 4, 1'b0);
    // R4 a larger divider.
    run_case(9, 1'b0, 1'b0, 1'b0, 2, 0, 64'h5, -1, 1'b0);

    @(negedge clk);
    finish_run();
  end

endmodule